// File: doc/BRIEF.md
# Return Address Stack with Interrupt Gating

This block keeps the return addresses of a small 8-bit controller core. It holds four program counter values and nothing else. The core pushes a PC value when it executes a subroutine call or takes an interrupt, and pops one when it executes either kind of return. The value that a return would restore is always shown on `top_pc`, so the core reads it in the same cycle as it raises `ret_pop`. Software cannot read or write the contents of the stack or its pointer.

The block also gates interrupt acknowledgement. While all four levels are occupied, `ack_allow` stays low, so a pending request is held off rather than taken. The request itself is kept by the interrupt controller outside this block. As soon as a return frees a level, the gate opens again. A subroutine call is never held off. A call made on a full stack still pushes, and the oldest address is lost, so the stack always holds the four most recent return addresses.

Every strobe is accepted in the cycle it is raised. There is no back-pressure on any port. An interrupt push that arrives while the stack is full, with no return in the same cycle, breaks the acknowledgement rule, and the block drops it. The depth must be a power of two.

Top module: `ret_stack`

## Requirements
- R1: After reset, `level` is 0, `empty` is 1 and `full` is 0.
- R2: A push (`call_push`, or `int_push` when it is accepted) stores `push_pc` on top. From the next cycle, `top_pc` equals that value and `level` has risen by one, up to 4.
- R3: `ret_pop` on a stack that is not empty removes the top entry. In the same cycle `top_pc` shows the value being restored. `level` falls by one, and the entries come back in reverse order of their pushes.
- R4: `full` is 1 exactly when `level` is 4, and `empty` is 1 exactly when `level` is 0.
- R5: A `call_push` made while the stack is full still stores `push_pc` on top. `level` stays at 4, and the oldest entry is discarded.
- R6: `ack_allow` is high, combinationally, exactly when `irq_pending` is high and `level` is below 4.
- R7: An `int_push` made while the stack is full and no `ret_pop` is raised is ignored. `level` and `top_pc` are unchanged in the next cycle.
- R8: A `ret_pop` and a push in the same cycle are resolved with the pop first. `level` is unchanged, and `top_pc` becomes the pushed value. This holds on a full stack as well.
- R9: `ret_pop` on an empty stack leaves `level` at 0 and `empty` at 1.
- R10: After a `ret_pop` on a full stack, `ack_allow` follows `irq_pending` again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_push | input | 1 | Push strobe from a subroutine call |
| int_push | input | 1 | Push strobe from an interrupt acknowledge |
| push_pc | input | PC_W | Return address to store |
| ret_pop | input | 1 | Pop strobe from either return instruction |
| irq_pending | input | 1 | An unmasked interrupt request is pending |
| top_pc | output | PC_W | Address a return would restore (meaningful when not empty) |
| level | output | $clog2(DEPTH)+1 | Number of occupied levels, 0 to 4 |
| full | output | 1 | All levels occupied |
| empty | output | 1 | No level occupied |
| ack_allow | output | 1 | Interrupt may be acknowledged this cycle |

## Verification
On every cycle, the assertions check the following:
- the bound on `level`;
- that `ack_allow` stays closed while the stack is full;
- that an empty pop leaves the stack empty;
- that a rejected interrupt push leaves `level` and `top_pc` unchanged;
- that a lone push adds exactly one level.

Other behaviours need whole sequences, and only the bench's scenarios can show them:
- the LIFO order of the data;
- the loss of the oldest entry when a call overflows the stack;
- the replacement of the top entry on a simultaneous pop and push;
- the gate reopening after a return.

The bench compares every cycle against a queue model.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stack_op_e;
endpackage

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr #(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  output logic [IDX_W-1:0] top_idx,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_en,
  output logic [CNT_W-1:0] count,
  output logic             pop_ok
);
  import ret_stack_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [IDX_W-1:0] wp_q;
  logic [CNT_W-1:0] cnt_q;
  stack_op_e        op;

  assign pop_ok  = pop_req && (cnt_q != '0);
  assign top_idx = wp_q - IDX_W'(1);
  assign count   = cnt_q;

  always_comb begin
    if (pop_ok && push_req)  op = OP_SWAP;
    else if (push_req)       op = OP_PUSH;
    else if (pop_ok)         op = OP_POP;
    else                     op = OP_IDLE;
  end

  assign wr_en  = (op == OP_PUSH) || (op == OP_SWAP);
  assign wr_idx = (op == OP_SWAP) ? top_idx : wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      case (op)
        OP_PUSH: begin
          wp_q <= wp_q + IDX_W'(1);
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
        end
        OP_POP: begin
          wp_q  <= wp_q - IDX_W'(1);
          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  // R4: occupancy never passes the depth
  a_r4_count_max: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R9: a pop on an empty stack keeps it empty
  a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && pop_req && !push_req) |=> (cnt_q == '0));

  // R2: a lone push below the depth adds exactly one level
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && cnt_q < CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/ret_stack_store.sv
module ret_stack_store #(
  parameter int DEPTH = 4,
  parameter int PC_W  = 11,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_data
);
  logic [PC_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/ret_stack_gate.sv
module ret_stack_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  input  logic pop_ok,
  input  logic irq_pending,
  input  logic call_push,
  input  logic int_push,
  output logic ack_allow,
  output logic push_req
);
  logic int_take;

  assign ack_allow = irq_pending && !full;
  assign int_take  = int_push && (!full || pop_ok);
  assign push_req  = call_push || int_take;

  // R6: the acknowledge gate is shut whenever the stack is full
  a_r6_gate_shut: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !ack_allow);
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 4,
  parameter int PC_W  = 11,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_push,
  input  logic             int_push,
  input  logic [PC_W-1:0]  push_pc,
  input  logic             ret_pop,
  input  logic             irq_pending,
  output logic [PC_W-1:0]  top_pc,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             ack_allow
);
  logic [IDX_W-1:0] top_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en;
  logic             pop_ok;
  logic             push_req;

  ret_stack_ptr #(.DEPTH(DEPTH)) ptr_i (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(ret_pop),
    .top_idx(top_idx), .wr_idx(wr_idx), .wr_en(wr_en),
    .count(level), .pop_ok(pop_ok)
  );

  ret_stack_store #(.DEPTH(DEPTH), .PC_W(PC_W)) store_i (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(push_pc),
    .rd_idx(top_idx), .rd_data(top_pc)
  );

  assign full  = (level == CNT_W'(DEPTH));
  assign empty = (level == '0);

  ret_stack_gate gate_i (
    .clk(clk), .rst_n(rst_n), .full(full), .pop_ok(pop_ok),
    .irq_pending(irq_pending), .call_push(call_push), .int_push(int_push),
    .ack_allow(ack_allow), .push_req(push_req)
  );

  // R7: an interrupt push refused on a full stack changes nothing
  a_r7_refused_int: assert property (@(posedge clk) disable iff (!rst_n)
    (full && int_push && !call_push && !ret_pop) |=> (full && $stable(top_pc)));
endmodule

// File: tb/ret_stack_tb_top.sv
module ret_stack_tb_top;
  localparam int PC_W = 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            call_push = 1'b0;
  logic            int_push = 1'b0;
  logic [PC_W-1:0] push_pc = '0;
  logic            ret_pop = 1'b0;
  logic            irq_pending = 1'b0;
  logic [PC_W-1:0] top_pc;
  logic [2:0]      level;
  logic            full;
  logic            empty;
  logic            ack_allow;

  int n_checks = 0;
  int n_fail = 0;
  int q[$];

  always #2 clk = ~clk;

  ret_stack #(.DEPTH(4), .PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .call_push(call_push), .int_push(int_push),
    .push_pc(push_pc), .ret_pop(ret_pop), .irq_pending(irq_pending),
    .top_pc(top_pc), .level(level), .full(full), .empty(empty),
    .ack_allow(ack_allow)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check(tag, "level", int'(level), q.size());
    check("R4", "full", int'(full), int'(q.size() == 4));
    check("R4", "empty", int'(empty), int'(q.size() == 0));
    if (q.size() > 0) check(tag, "top_pc", int'(top_pc), q[$]);
  endtask

  // Drives one cycle: inputs after a falling edge, combinational checks
  // before the rising edge, model update, then state checks after the edge.
  task automatic step(input bit c, input bit ip, input bit p, input bit irq,
                      input int pc, input string tag);
    bit pe;
    bit it;
    call_push = c; int_push = ip; ret_pop = p; irq_pending = irq;
    push_pc = PC_W'(pc);
    #1;
    check("R6", "ack_allow", int'(ack_allow), int'(irq && q.size() < 4));
    if (p && q.size() > 0) check("R3", "top_pc at pop", int'(top_pc), q[$]);
    pe = p && (q.size() > 0);
    it = ip && (q.size() < 4 || pe);
    @(posedge clk);
    if (pe) void'(q.pop_back());
    if (c || it) begin
      q.push_back(pc & ((1 << PC_W) - 1));
      if (q.size() > 4) void'(q.pop_front());
    end
    @(negedge clk);
    call_push = 0; int_push = 0; ret_pop = 0;
    check_state(tag);
  endtask

  initial begin
    #20000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check_state("R1");
    check("R1", "reset empty", int'(empty), 1);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 1, 0, 0, "R9");
    check("R9", "empty after empty pop", int'(empty), 1);
    step(1, 0, 0, 1, 11'h101, "R2");
    step(0, 1, 0, 1, 11'h202, "R2");
    step(1, 0, 0, 0, 11'h303, "R2");
    step(1, 0, 0, 1, 11'h404, "R4");
    check("R4", "full", int'(full), 1);
    step(0, 1, 0, 1, 11'h555, "R7");
    check("R7", "top kept", int'(top_pc), 11'h404);
    step(1, 0, 0, 1, 11'h606, "R5");
    check("R5", "top after overflow", int'(top_pc), 11'h606);
    step(0, 1, 1, 1, 11'h707, "R8");
    check("R8", "swap on full", int'(top_pc), 11'h707);
    step(0, 0, 1, 1, 0, "R3");
    irq_pending = 1'b1;
    #1;
    check("R10", "gate reopened", int'(ack_allow), 1);
    step(1, 0, 1, 0, 11'h0AA, "R8");
    step(0, 0, 1, 0, 0, "R3");
    step(0, 0, 1, 0, 0, "R3");
    check("R3", "oldest surviving", int'(top_pc), 11'h202);
    step(0, 0, 1, 0, 0, "R3");
    step(0, 0, 1, 0, 0, "R9");
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 7));
      step(r == 0 || r == 1 || r == 6, r == 2 || r == 3, r >= 3 && r <= 5,
           r[0], int'($urandom_range(0, 2047)), "R2");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule